// File: doc/BRIEF.md
# Set-Associative Last-Use Predictor

This block sits beside the decode stage of an out-of-order core. For every decoded instruction it looks up the fetch PC and predicts which of the instruction's register references are the final read or write of their physical register: the destination, the first source and the second source. The rename stage can then free a predicted-dead register early instead of waiting for the next writer of the same logical register. The prediction is speculative. Claiming a last use that is not real frees a register too soon. Missing one only wastes an opportunity. For that reason every unknown case answers "not a last use".

The table has two ways per set and one replacement bit per set. Lookup is purely combinational from the PC. Training comes only from the commit stage, which presents the retired PC and its true last-use bits. Committed patterns are sticky: the table keeps a stored pattern and returns it for every later instance of the same PC until the same PC commits again with different bits. A per-slot operand-valid input clears the prediction for slots the instruction does not have.

Top module: `lup_predictor`

## Requirements
- R1: The PC is split with bits [1:0] ignored, bits [IDX_W+1:2] as the set index and the remaining upper bits as the tag. PCs that share a set but differ in tag are stored and predicted independently, and PCs in different sets never interfere.
- R2: A lookup that matches no valid entry returns lk_hit = 0 and lk_lu = 3'b000.
- R3: A lookup that matches a valid entry returns lk_hit = 1 and the stored pattern. Bit 0 is the destination, bit 1 is source 1 and bit 2 is source 2, and a 1 means "last use".
- R4: lk_lu is the stored pattern ANDed with lk_opnd_vld, which uses the same bit order. A 0 slot always reads as 0. lk_hit is not affected by the mask.
- R5: A commit update is written at the rising clock edge. A lookup of the same PC in the update cycle sees the old contents, and from the next cycle it sees the new pattern.
- R6: A commit update whose PC already has an entry overwrites only that entry's pattern. The entry is never duplicated, and the pattern persists until that PC is updated again.
- R7: A commit update that misses fills an invalid way, way 0 before way 1. If both ways are valid, it replaces the least recently updated way. Each update, hit or miss, marks the way it wrote as most recent.
- R8: Lookups never change table contents or replacement state. Only commit updates train the table.
- R9: A synchronous reset clears every valid bit, so that after the reset edge every lookup misses.
- R10: ENTRIES is a power-of-two parameter from 32 to 8192 (2 ways, ENTRIES/2 sets).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lk_pc | input | PC_W | PC of the instruction being decoded |
| lk_opnd_vld | input | 3 | Slots present in the instruction: bit0 dest, bit1 src1, bit2 src2 |
| lk_hit | output | 1 | Tag match on a valid entry |
| lk_lu | output | 3 | Predicted last-use bits, masked by lk_opnd_vld |
| upd_en | input | 1 | Commit-time training request |
| upd_pc | input | PC_W | PC of the retired instruction |
| upd_lu | input | 3 | True last-use bits of the retired instruction |

## Verification
Lookup results are combinational and are due in the same cycle the PC is applied. The bench drives the PC on the falling edge and samples one nanosecond later. A commit update takes effect at the next rising edge. The bench therefore checks the old contents in the update cycle itself and checks the new contents at the following falling edge. Reset clears the table at the edge where rst is sampled high, and misses are checked after that edge. Replacement is checked through lookups in the cycle after each update, by observing which of three or four same-set PCs has been evicted.

// File: rtl/lup_pkg.sv
package lup_pkg;
  // Slot order shared by pattern and operand-valid vectors.
  localparam int SLOT_DST  = 0;
  localparam int SLOT_SRC1 = 1;
  localparam int SLOT_SRC2 = 2;
  localparam int SLOTS     = 3;

  typedef logic [SLOTS-1:0] lu_pat_t;
  typedef logic [1:0]       way_vec_t;

  // Victim choice for a two-way set: hit way, else first empty, else LRU.
  function automatic way_vec_t pick_way(way_vec_t hit, way_vec_t vld, logic lru_is_w1);
    way_vec_t r;
    if (hit != 2'b00)  r = hit;
    else if (!vld[0])  r = 2'b01;
    else if (!vld[1])  r = 2'b10;
    else if (lru_is_w1) r = 2'b10;
    else               r = 2'b01;
    return r;
  endfunction
endpackage

// File: rtl/lup_way.sv
module lup_way
  import lup_pkg::*;
#(
  parameter int SETS  = 256,
  parameter int IDX_W = 8,
  parameter int TAG_W = 22
) (
  input  logic             clk,
  input  logic             rst,
  // combinational lookup port
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [TAG_W-1:0] rd_tag,
  output logic             rd_hit,
  output lu_pat_t          rd_lu,
  // combinational probe for the update path
  input  logic [IDX_W-1:0] pr_idx,
  input  logic [TAG_W-1:0] pr_tag,
  output logic             pr_hit,
  output logic             pr_vld,
  // write port
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  lu_pat_t          wr_lu
);
  logic [SETS-1:0]  valid_q;
  logic [TAG_W-1:0] tag_q [SETS];
  lu_pat_t          pat_q [SETS];

  always_ff @(posedge clk) begin
    if (rst)        valid_q <= '0;
    else if (wr_en) valid_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx] <= wr_tag;
      pat_q[wr_idx] <= wr_lu;
    end
  end

  always_comb begin
    rd_hit = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
    rd_lu  = pat_q[rd_idx];
    pr_vld = valid_q[pr_idx];
    pr_hit = pr_vld && (tag_q[pr_idx] == pr_tag);
  end

  // R9: the cycle after reset, the write-side probe sees no valid entry
  a_r9_way_cleared: assert property (@(posedge clk)
    $past(rst) && !rst |-> !pr_vld);
endmodule

// File: rtl/lup_victim.sv
module lup_victim
  import lup_pkg::*;
#(
  parameter int SETS  = 256,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  way_vec_t         hit_vec,
  input  way_vec_t         vld_vec,
  output way_vec_t         wr_way
);
  // lru_q[s] = 1 means way 1 is the least recently updated way of set s
  logic [SETS-1:0] lru_q;

  always_comb wr_way = upd_en ? pick_way(hit_vec, vld_vec, lru_q[upd_idx]) : 2'b00;

  always_ff @(posedge clk) begin
    if (rst)         lru_q <= '0;
    else if (upd_en) lru_q[upd_idx] <= wr_way[0];
  end

  // R6: a PC is never held in both ways of a set
  a_r6_single_match: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));
  // R7: every update writes exactly one way
  a_r7_one_write: assert property (@(posedge clk) disable iff (rst)
    upd_en |-> $onehot(wr_way));
  // R7: a full set with no match never overwrites the most recent way
  a_r7_full_uses_lru: assert property (@(posedge clk) disable iff (rst)
    (upd_en && hit_vec == 2'b00 && vld_vec == 2'b11) |-> (wr_way[1] == lru_q[upd_idx]));
  // R7: an empty way is used before any eviction
  a_r7_empty_first: assert property (@(posedge clk) disable iff (rst)
    (upd_en && hit_vec == 2'b00 && !vld_vec[0]) |-> wr_way == 2'b01);
endmodule

// File: rtl/lup_predictor.sv
module lup_predictor
  import lup_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int PC_LSB  = 2,
  parameter int ENTRIES = 512
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PC_W-1:0]  lk_pc,
  input  logic [2:0]       lk_opnd_vld,
  output logic             lk_hit,
  output logic [2:0]       lk_lu,
  input  logic             upd_en,
  input  logic [PC_W-1:0]  upd_pc,
  input  logic [2:0]       upd_lu
);
  localparam int WAYS  = 2;
  localparam int SETS  = ENTRIES / WAYS;
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = PC_W - IDX_W - PC_LSB;

  initial begin
    if (ENTRIES < 32 || ENTRIES > 8192 || (ENTRIES & (ENTRIES - 1)) != 0)
      $error("R10: ENTRIES must be a power of two in 32..8192");
  end

  function automatic logic [IDX_W-1:0] set_of(logic [PC_W-1:0] pc);
    return pc[PC_LSB +: IDX_W];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(logic [PC_W-1:0] pc);
    return pc[PC_W-1 -: TAG_W];
  endfunction

  logic unused_pc_low;
  assign unused_pc_low = ^{lk_pc[PC_LSB-1:0], upd_pc[PC_LSB-1:0]};

  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0] lk_tag, up_tag;
  assign lk_idx = set_of(lk_pc);
  assign lk_tag = tag_of(lk_pc);
  assign up_idx = set_of(upd_pc);
  assign up_tag = tag_of(upd_pc);

  way_vec_t rd_hit_vec, pr_hit_vec, pr_vld_vec, wr_way;
  lu_pat_t  rd_lu_way [WAYS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    lup_way #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_way (
      .clk    (clk),
      .rst    (rst),
      .rd_idx (lk_idx),
      .rd_tag (lk_tag),
      .rd_hit (rd_hit_vec[w]),
      .rd_lu  (rd_lu_way[w]),
      .pr_idx (up_idx),
      .pr_tag (up_tag),
      .pr_hit (pr_hit_vec[w]),
      .pr_vld (pr_vld_vec[w]),
      .wr_en  (wr_way[w]),
      .wr_idx (up_idx),
      .wr_tag (up_tag),
      .wr_lu  (upd_lu)
    );
  end

  lup_victim #(.SETS(SETS), .IDX_W(IDX_W)) u_victim (
    .clk     (clk),
    .rst     (rst),
    .upd_en  (upd_en),
    .upd_idx (up_idx),
    .hit_vec (pr_hit_vec),
    .vld_vec (pr_vld_vec),
    .wr_way  (wr_way)
  );

  // Named internal events for the assertions
  logic    raw_hit;
  lu_pat_t raw_lu;
  always_comb begin
    raw_hit = 1'b0;
    raw_lu  = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (rd_hit_vec[w]) begin
        raw_hit = 1'b1;
        raw_lu  = raw_lu | rd_lu_way[w];
      end
    end
  end

  assign lk_hit = raw_hit;
  assign lk_lu  = raw_lu & lk_opnd_vld;

  // R2: a miss never predicts a last use
  a_r2_miss_is_zero: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> lk_lu == 3'b000);
  // R4: an absent slot never reads as a last use
  a_r4_absent_slot: assert property (@(posedge clk) disable iff (rst)
    (lk_lu & ~lk_opnd_vld) == 3'b000);
  // R5: an update is visible to a lookup of the same PC one cycle later
  a_r5_next_cycle: assert property (@(posedge clk) disable iff (rst)
    upd_en ##1 (lk_pc == $past(upd_pc)) |-> lk_hit && lk_lu == ($past(upd_lu) & lk_opnd_vld));
  // R8: the lookup port does not change anything the update probe sees
  a_r8_probe_stable: assert property (@(posedge clk) disable iff (rst)
    !$past(upd_en) && $stable(upd_pc) && !$past(rst) |-> $stable(pr_vld_vec) && $stable(pr_hit_vec));
  // R9: the cycle after reset nothing hits
  a_r9_reset_clear: assert property (@(posedge clk)
    $past(rst) && !rst |-> !lk_hit);
endmodule

// File: tb/lup_predictor_tb.sv
`timescale 1ns/1ps
module lup_predictor_tb;
  localparam int PC_W = 32;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [PC_W-1:0] lk_pc = '0;
  logic [2:0]      lk_opnd_vld = 3'b111;
  logic            lk_hit;
  logic [2:0]      lk_lu;
  logic            upd_en = 1'b0;
  logic [PC_W-1:0] upd_pc = '0;
  logic [2:0]      upd_lu = '0;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  lup_predictor #(.PC_W(PC_W), .PC_LSB(2), .ENTRIES(512)) u_dut (
    .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_opnd_vld(lk_opnd_vld),
    .lk_hit(lk_hit), .lk_lu(lk_lu), .upd_en(upd_en), .upd_pc(upd_pc), .upd_lu(upd_lu));

  // 256 sets: set in pc[9:2], tag in pc[31:10]
  function automatic logic [31:0] mk_pc(int tag, int set, int low = 0);
    return (32'(tag) << 10) | (32'(set & 255) << 2) | 32'(low & 3);
  endfunction

  task automatic expect_lk(string req, logic [31:0] pc, logic [2:0] vld, logic eh, logic [2:0] el);
    lk_pc = pc;
    lk_opnd_vld = vld;
    #1;
    checks++;
    if (lk_hit !== eh || lk_lu !== el) begin
      errors++;
      $display("FAIL %s pc=%h actual hit=%b lu=%b expected hit=%b lu=%b",
               req, pc, lk_hit, lk_lu, eh, el);
    end
  endtask

  task automatic commit(logic [31:0] pc, logic [2:0] lu);
    @(negedge clk);
    upd_en = 1'b1; upd_pc = pc; upd_lu = lu;
    @(negedge clk);
    upd_en = 1'b0;
  endtask

  task automatic t_reset_state();
    expect_lk("R9", mk_pc(0, 0), 3'b111, 1'b0, 3'b000);
    expect_lk("R2", mk_pc(7, 33), 3'b111, 1'b0, 3'b000);
  endtask

  task automatic t_hit_pattern();
    commit(mk_pc(1, 10), 3'b101);
    expect_lk("R3", mk_pc(1, 10), 3'b111, 1'b1, 3'b101);
    expect_lk("R1", mk_pc(1, 10, 3), 3'b111, 1'b1, 3'b101); // low bits ignored
    expect_lk("R1", mk_pc(1, 11), 3'b111, 1'b0, 3'b000);    // other set
    expect_lk("R2", mk_pc(2, 10), 3'b111, 1'b0, 3'b000);    // other tag
  endtask

  task automatic t_mask();
    commit(mk_pc(3, 20), 3'b111);
    expect_lk("R4", mk_pc(3, 20), 3'b011, 1'b1, 3'b011);
    expect_lk("R4", mk_pc(3, 20), 3'b101, 1'b1, 3'b101);
    expect_lk("R4", mk_pc(3, 20), 3'b000, 1'b1, 3'b000);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    upd_en = 1'b1; upd_pc = mk_pc(4, 30); upd_lu = 3'b010;
    expect_lk("R5", mk_pc(4, 30), 3'b111, 1'b0, 3'b000);
    @(negedge clk);
    upd_en = 1'b0;
    expect_lk("R5", mk_pc(4, 30), 3'b111, 1'b1, 3'b010);
    @(negedge clk);
    upd_en = 1'b1; upd_pc = mk_pc(4, 30); upd_lu = 3'b100;
    expect_lk("R5", mk_pc(4, 30), 3'b111, 1'b1, 3'b010);
    @(negedge clk);
    upd_en = 1'b0;
    expect_lk("R6", mk_pc(4, 30), 3'b111, 1'b1, 3'b100);
  endtask

  task automatic t_alias_and_replace();
    commit(mk_pc(10, 5), 3'b001);
    commit(mk_pc(11, 5), 3'b010);
    expect_lk("R1", mk_pc(10, 5), 3'b111, 1'b1, 3'b001);
    expect_lk("R1", mk_pc(11, 5), 3'b111, 1'b1, 3'b010);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      expect_lk("R8", mk_pc(10, 5), 3'b111, 1'b1, 3'b001);
    end
    commit(mk_pc(12, 5), 3'b100);
    expect_lk("R8", mk_pc(10, 5), 3'b111, 1'b0, 3'b000);
    expect_lk("R7", mk_pc(11, 5), 3'b111, 1'b1, 3'b010);
    expect_lk("R7", mk_pc(12, 5), 3'b111, 1'b1, 3'b100);
    commit(mk_pc(11, 5), 3'b011);
    expect_lk("R6", mk_pc(11, 5), 3'b111, 1'b1, 3'b011);
    commit(mk_pc(13, 5), 3'b110);
    expect_lk("R7", mk_pc(12, 5), 3'b111, 1'b0, 3'b000);
    expect_lk("R7", mk_pc(11, 5), 3'b111, 1'b1, 3'b011);
    expect_lk("R7", mk_pc(13, 5), 3'b111, 1'b1, 3'b110);
    expect_lk("R1", mk_pc(1, 10), 3'b111, 1'b1, 3'b101);
  endtask

  task automatic t_reset_clears();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    expect_lk("R9", mk_pc(11, 5), 3'b111, 1'b0, 3'b000);
    expect_lk("R9", mk_pc(3, 20), 3'b111, 1'b0, 3'b000);
    commit(mk_pc(20, 5), 3'b001);
    expect_lk("R10", mk_pc(20, 5), 3'b111, 1'b1, 3'b001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_hit_pattern();
    t_mask();
    t_same_cycle();
    t_alias_and_replace();
    t_reset_clears();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule